// File: doc/BRIEF.md
# Colour Expander and 2x Upscaler

This streaming stage turns a low-resolution frame of 16-bit 5-6-5 pixels into a frame of twice the width and twice the height, with 30-bit output pixels. Each colour channel is widened to 10 bits by bit replication, so black stays all zeros and white becomes all ones. Each input pixel is sent twice in a row. Each input line is sent once as it arrives and then a second time from an internal line buffer. The defaults give a 320x240 input and a 640x480 output.

Both sides use valid/ready handshakes and carry a start-of-frame flag and an end-of-frame flag. The input stalls while a line is being replayed. Upstream logic therefore sees an average acceptance rate of one pixel every four output cycles. The output frame markers are rebuilt from the stage's own row and column counters. Clock-domain crossing and display timing are handled by other blocks.

Top module: `pix_upscale2x`

## Requirements
- R1: An input pixel carries red in bits 15:11, green in bits 10:5 and blue in bits 4:0. The output places red in bits 29:20, green in bits 19:10 and blue in bits 9:0. Red and blue become {v,v}, and green becomes {v,v[5:2]}.
- R2: Input 16'h0000 gives output 30'h0000_0000, and input 16'hFFFF gives output 30'h3FFF_FFFF.
- R3: Each accepted input pixel appears on the output as two consecutive identical pixels.
- R4: Once the last pixel of an input line has been sent twice, the whole line is sent again from the buffer, pixel for pixel and each pixel twice.
- R5: After reset the output is not valid and inReady is high. While a line is being replayed, inReady is low.
- R6: outSof is high only with the first copy of the first pixel of row 0.
- R7: outEof is high only with the second copy of the last pixel of the replayed last line of the frame.
- R8: While outValid is high and outReady is low, outValid stays high and outData does not change in the next cycle.
- R9: A complete input frame of LINE_W x FRAME_H pixels produces exactly 4·LINE_W·FRAME_H output pixels.
- R10: An input pixel that carries inSof restarts the frame at row 0, column 0, even in the middle of a line. A partly received line is not replayed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Stage can take an input pixel |
| inData | input | 16 | 5-6-5 input pixel |
| inSof | input | 1 | Input pixel is the first of a frame |
| inEof | input | 1 | Input pixel is the last of a frame (protocol check only) |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Downstream takes the output pixel |
| outData | output | 30 | 10-10-10 output pixel |
| outSof | output | 1 | First output pixel of a frame |
| outEof | output | 1 | Last output pixel of a frame |

## Verification
The hardest case to reach is a frame restart in the middle of a line. A new start-of-frame must throw away a partly received line without replaying it. The stimulus sends one full line, then only two pixels of the next line, and then a new frame whose first pixel carries the start flag. Random gaps on the input and random output back-pressure run at the same time. This places the line-end switch to replay, and the hold-while-stalled rule, on many different cycle alignments.

// File: rtl/upx_pkg.sv
`timescale 1ns/1ps
package upx_pkg;

  typedef struct packed {
    logic load;       // capture inData into the hold register
    logic wrEn;       // write inData into the line buffer
    logic selReplay;  // output source: line buffer instead of hold register
  } upx_strobe_t;

  // 5-6-5 to 10-10-10 by bit replication (pure wiring)
  function automatic logic [29:0] widen565(input logic [15:0] p);
    logic [4:0] r;
    logic [5:0] g;
    logic [4:0] b;
    r = p[15:11];
    g = p[10:5];
    b = p[4:0];
    return {r, r, g, g[5:2], b, b};
  endfunction

endpackage

// File: rtl/upx_ctrl.sv
`timescale 1ns/1ps
module upx_ctrl
  import upx_pkg::*;
#(
  parameter int LINE_W  = 320,
  parameter int FRAME_H = 240,
  localparam int CW = (LINE_W  > 1) ? $clog2(LINE_W)  : 1,
  localparam int RW = (FRAME_H > 1) ? $clog2(FRAME_H) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inSof,
  input  logic          inEof,
  output logic          inReady,
  input  logic          outReady,
  output logic          outValid,
  output logic          outSof,
  output logic          outEof,
  output logic          firstCopy,
  output upx_strobe_t   strobe,
  output logic [CW-1:0] wrAddr,
  output logic [CW-1:0] rdAddr
);

  localparam logic [CW-1:0] COL_LAST = CW'(LINE_W - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(FRAME_H - 1);

  typedef enum logic {ST_LIVE, ST_REPLAY} upx_state_t;

  upx_state_t    state;
  logic          holdValid;
  logic          holdLast;
  logic          holdSof;
  logic          phase;      // 0: first copy, 1: second copy
  logic [CW-1:0] col;        // column of the next accepted pixel
  logic [CW-1:0] repCol;     // replay read column
  logic [RW-1:0] row;        // current input row

  logic          live;
  logic          pop;
  logic          accept;
  logic [CW-1:0] acceptCol;
  logic [RW-1:0] acceptRow;

  always_comb begin
    live      = (state == ST_LIVE);
    pop       = live && holdValid && phase && outReady;
    inReady   = live && (!holdValid || (pop && !holdLast));
    accept    = inValid && inReady;
    acceptCol = inSof ? '0 : col;
    acceptRow = inSof ? '0 : row;

    outValid  = live ? holdValid : 1'b1;
    outSof    = live && holdValid && holdSof && !phase;
    outEof    = !live && phase && (repCol == COL_LAST) && (row == ROW_LAST);
    firstCopy = outValid && !phase;

    strobe.load      = accept;
    strobe.wrEn      = accept;
    strobe.selReplay = !live;
    wrAddr           = acceptCol;
    rdAddr           = repCol;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_LIVE;
      holdValid <= 1'b0;
      holdLast  <= 1'b0;
      holdSof   <= 1'b0;
      phase     <= 1'b0;
      col       <= '0;
      repCol    <= '0;
      row       <= '0;
    end else if (live) begin
      if (accept) begin
        holdValid <= 1'b1;
        phase     <= 1'b0;
        holdLast  <= (acceptCol == COL_LAST);
        holdSof   <= (acceptCol == '0) && (acceptRow == '0);
        col       <= (acceptCol == COL_LAST) ? '0 : acceptCol + 1'b1;
        row       <= acceptRow;
      end else if (pop) begin
        holdValid <= 1'b0;
        phase     <= 1'b0;
        if (holdLast) begin
          state  <= ST_REPLAY;
          repCol <= '0;
        end
      end else if (holdValid && outReady) begin
        phase <= 1'b1;
      end
    end else if (outReady) begin
      if (phase) begin
        phase <= 1'b0;
        if (repCol == COL_LAST) begin
          state <= ST_LIVE;
          row   <= (row == ROW_LAST) ? '0 : row + 1'b1;
        end else begin
          repCol <= repCol + 1'b1;
        end
      end else begin
        phase <= 1'b1;
      end
    end
  end

  // R7: end-of-frame never shares a pixel with start-of-frame
  p_markers_apart_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(outSof && outEof));

  // R5: the line-end pop switches to replay and closes the input the next cycle
  p_replay_closes_input_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pop && holdLast) |=> (!inReady && outValid));

  // R9: an input end-of-frame must fall on the last pixel of the last row
  p_input_eof_position_r9: assert property (@(posedge clk) disable iff (!rstN)
    (accept && inEof) |-> ((acceptCol == COL_LAST) && (acceptRow == ROW_LAST)));

endmodule

// File: rtl/upx_datapath.sv
`timescale 1ns/1ps
module upx_datapath
  import upx_pkg::*;
#(
  parameter int LINE_W = 320,
  localparam int CW = (LINE_W > 1) ? $clog2(LINE_W) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  upx_strobe_t   strobe,
  input  logic [CW-1:0] wrAddr,
  input  logic [CW-1:0] rdAddr,
  input  logic [15:0]   inData,
  output logic [29:0]   outData
);

  logic [15:0] holdPix;
  logic [15:0] lineBuf [LINE_W];
  logic [15:0] srcPix;

  always_ff @(posedge clk) begin
    if (!rstN)            holdPix <= '0;
    else if (strobe.load) holdPix <= inData;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) lineBuf[wrAddr] <= inData;
  end

  always_comb begin
    srcPix  = strobe.selReplay ? lineBuf[rdAddr] : holdPix;
    outData = widen565(srcPix);
  end

  // R5: the buffer is never written while it is being replayed
  p_no_write_in_replay_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selReplay |-> !strobe.wrEn);

endmodule

// File: rtl/pix_upscale2x.sv
`timescale 1ns/1ps
module pix_upscale2x
  import upx_pkg::*;
#(
  parameter int LINE_W  = 320,
  parameter int FRAME_H = 240
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [15:0] inData,
  input  logic        inSof,
  input  logic        inEof,
  output logic        outValid,
  input  logic        outReady,
  output logic [29:0] outData,
  output logic        outSof,
  output logic        outEof
);

  localparam int CW = (LINE_W > 1) ? $clog2(LINE_W) : 1;

  upx_strobe_t   strobe;
  logic [CW-1:0] wrAddr;
  logic [CW-1:0] rdAddr;
  logic          firstCopy;

  upx_ctrl #(.LINE_W(LINE_W), .FRAME_H(FRAME_H)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inSof     (inSof),
    .inEof     (inEof),
    .inReady   (inReady),
    .outReady  (outReady),
    .outValid  (outValid),
    .outSof    (outSof),
    .outEof    (outEof),
    .firstCopy (firstCopy),
    .strobe    (strobe),
    .wrAddr    (wrAddr),
    .rdAddr    (rdAddr)
  );

  upx_datapath #(.LINE_W(LINE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .inData  (inData),
    .outData (outData)
  );

  // R8: a stalled output holds its value
  p_hold_when_stalled_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R3 / R4: the second copy follows the first one and matches it
  p_second_copy_same_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && firstCopy) |=> (outValid && $stable(outData)));

endmodule

// File: tb/pix_upscale2x_tb.sv
`timescale 1ns/1ps
module pix_upscale2x_tb;

  localparam int W = 4;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inData = '0;
  logic        inSof = 1'b0;
  logic        inEof = 1'b0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [29:0] outData;
  logic        outSof;
  logic        outEof;

  always #2.5 clk = ~clk;

  pix_upscale2x #(.LINE_W(W), .FRAME_H(H)) u_dut (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .inSof(inSof), .inEof(inEof),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outSof(outSof), .outEof(outEof)
  );

  typedef struct {
    logic [29:0] d;
    logic        sof;
    logic        eof;
    string       tag;
  } item_t;

  item_t       q[$];
  int          nCmp = 0;
  int          nBad = 0;
  int          outCount = 0;
  bit          gapsOn = 1'b0;
  bit          bpOn = 1'b0;
  bit          monOn = 1'b0;
  bit          finished = 1'b0;
  logic [15:0] linePix [W];

  function automatic logic [29:0] refWiden(input logic [15:0] p);
    logic [9:0] r, g, b;
    r = {p[15:11], p[15:11]};
    g = {p[10:5], p[10:7]};
    b = {p[4:0], p[4:0]};
    return {r, g, b};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic pushItem(input logic [15:0] p, input bit sof, input bit eof,
                          input string tag);
    item_t it;
    it.d = refWiden(p);
    it.sof = sof;
    it.eof = eof;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic sendPix(input logic [15:0] p, input bit sof, input bit eof,
                         input string tag);
    bit done = 1'b0;
    while (!done) begin
      @(negedge clk);
      inValid = gapsOn ? ($urandom % 4 != 0) : 1'b1;
      inData  = p;
      inSof   = sof;
      inEof   = eof;
      #1;
      if (inValid && inReady) begin
        pushItem(p, sof, 1'b0, sof ? "R6" : tag);
        pushItem(p, 1'b0, 1'b0, tag);
        done = 1'b1;
      end
    end
  endtask

  task automatic sendLine(input bit firstRow, input bit lastRow,
                          input string tag, input int nPix);
    for (int c = 0; c < nPix; c++)
      sendPix(linePix[c], firstRow && c == 0, lastRow && c == W - 1, tag);
    if (nPix == W) begin
      for (int c = 0; c < W; c++) begin
        pushItem(linePix[c], 1'b0, 1'b0, "R4");
        pushItem(linePix[c], 1'b0, lastRow && c == W - 1,
                 (lastRow && c == W - 1) ? "R7" : "R4");
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    inSof   = 1'b0;
    inEof   = 1'b0;
  endtask

  task automatic randomLine();
    for (int c = 0; c < W; c++) linePix[c] = 16'($urandom);
  endtask

  task automatic randomFrame(input string tag);
    for (int r = 0; r < H; r++) begin
      randomLine();
      sendLine(r == 0, r == H - 1, tag, W);
    end
  endtask

  // monitor / scoreboard
  initial begin
    bit          stalled = 1'b0;
    logic [29:0] heldData = '0;
    item_t       it;
    forever begin
      @(negedge clk);
      outReady = bpOn ? ($urandom % 3 != 0) : 1'b1;
      #1;
      if (monOn) begin
        if (stalled) begin
          check(outValid == 1'b1, "R8", "valid dropped while stalled", 32'(outValid), 32'd1);
          check(outData == heldData, "R8", "data moved while stalled", 32'(outData), 32'(heldData));
        end
        stalled  = outValid && !outReady;
        heldData = outData;
        if (outValid && q.size() != 0 && (q[0].tag == "R4" || q[0].tag == "R7"))
          check(inReady == 1'b0, "R5", "inReady during replay", 32'(inReady), 32'd0);
        if (outValid && outReady) begin
          outCount++;
          if (q.size() == 0) begin
            check(1'b0, "R9", "unexpected output pixel", 32'(outData), 32'd0);
          end else begin
            it = q.pop_front();
            check(outData == it.d, it.tag, "data", 32'(outData), 32'(it.d));
            check(outSof == it.sof, it.sof ? "R6" : it.tag, "sof", 32'(outSof), 32'(it.sof));
            check(outEof == it.eof, it.eof ? "R7" : it.tag, "eof", 32'(outEof), 32'(it.eof));
          end
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL watchdog expired: actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int waitCnt;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R5: idle state after reset
    check(outValid == 1'b0, "R5", "outValid after reset", 32'(outValid), 32'd0);
    check(inReady == 1'b1, "R5", "inReady after reset", 32'(inReady), 32'd1);
    monOn = 1'b1;

    // Frame 1: full-scale and single-channel pixels, with gaps and back-pressure
    gapsOn = 1'b1;
    bpOn   = 1'b1;
    linePix[0] = 16'h0000; linePix[1] = 16'hFFFF;
    linePix[2] = 16'hF800; linePix[3] = 16'h07E0;
    for (int c = 0; c < W; c++)
      sendPix(linePix[c], c == 0, 1'b0, (c < 2) ? "R2" : "R1");
    for (int c = 0; c < W; c++) begin
      pushItem(linePix[c], 1'b0, 1'b0, "R4");
      pushItem(linePix[c], 1'b0, 1'b0, "R4");
    end
    @(negedge clk);
    inValid = 1'b0;
    inSof   = 1'b0;
    linePix[0] = 16'h001F; linePix[1] = 16'h1234;
    linePix[2] = 16'hABCD; linePix[3] = 16'h8421;
    sendLine(1'b0, 1'b0, "R1", W);
    randomLine();
    sendLine(1'b0, 1'b1, "R3", W);

    // Frame 2: full throughput
    gapsOn = 1'b0;
    bpOn   = 1'b0;
    randomFrame("R3");

    // Frame 3 aborted mid-line, then frame 4 restarts with inSof (R10)
    gapsOn = 1'b1;
    bpOn   = 1'b1;
    randomLine();
    sendLine(1'b1, 1'b0, "R3", W);
    randomLine();
    sendLine(1'b0, 1'b0, "R10", 2);
    randomFrame("R10");

    waitCnt = 0;
    while (q.size() != 0 && waitCnt < 2000) begin
      @(negedge clk);
      waitCnt++;
    end
    repeat (20) @(negedge clk);
    check(q.size() == 0, "R9", "expected pixels left over", 32'(q.size()), 32'd0);
    check(outCount == 3 * 4 * W * H + 4 * W + 4, "R9", "total output pixels",
          32'(outCount), 32'(3 * 4 * W * H + 4 * W + 4));
    summary();
    $finish;
  end

endmodule